// File: doc/BRIEF.md
# Prescaled Capture/Match Timer

This block is a general-purpose timer for a peripheral subsystem. A 32-bit main counter advances either on prescaled peripheral clock ticks or on edges seen at one of the capture pins. Four capture channels copy the counter into their own register when a chosen edge arrives. Four match channels compare the counter against programmed values. On a match a channel can clear or freeze the counter, raise an interrupt flag and change its external output pin.

Software drives everything through a simple single-cycle register bus. A write takes effect at the clock edge where `bus_we` is high. Reads are combinational from `bus_addr`. All flags are collected into one level interrupt line.

Top module: `tcm_timer`

## Requirements
- R1: After reset every register reads zero, all match pins are low and `irq` is low.
- R2: In clock mode (MODE[1:0]=0), with RUN set and HOLD clear, the prescale count rises by one each cycle. In the cycle where it equals the prescale limit it returns to zero and the main counter takes one step, so the counter steps once every limit+1 cycles.
- R3: While HOLD (CTRL bit 1) is set, the main counter and the prescale count are forced to zero from the next edge on, and no step or match event occurs.
- R4: While RUN (CTRL bit 0) is clear, the main counter and the prescale count keep their values.
- R5: Capture channel i copies the current counter into its capture register on a synchronized rising edge if CCFG bit 3i is set, and on a falling edge if CCFG bit 3i+1 is set.
- R6: A capture sets flag bit N+i (FLAGS bits 7:4) only when CCFG bit 3i+2 is set.
- R7: A match event on channel i is a counter step taken while the counter equals MATCH i. It sets flag bit i (FLAGS bits 3:0) when MACT bit 3i is set.
- R8: When MACT bit 3i+1 is set, a match event sends the counter to zero instead of incrementing it, giving a period of MATCH i + 1 steps.
- R9: When MACT bit 3i+2 is set, a match event clears RUN and the counter keeps its value. Stop takes priority over a software write of RUN in the same cycle.
- R10: On a match event, pin i follows OCFG bits [2i+1:2i]: 0 keep, 1 drive low, 2 drive high, 3 toggle.
- R11: Writing a 1 to a FLAGS bit clears that bit. `irq` is high exactly while any flag is set, and it stays high until a flag clear is written.
- R12: In counter mode, MODE[3:2] selects a capture pin and MODE[1:0] selects which edges step the counter: 1 rising, 2 falling, 3 both. The prescale count stays at zero in this mode.
- R13: Capture pins pass through two synchronizing flops. A level change set up before edge E is acted on at edge E+2.
- R14: The word offsets are: 0 CTRL, 1 MODE, 2 prescale limit, 3 prescale count (read only), 4 counter (read only), 5 FLAGS, 6 MACT, 7 CCFG, 8 OCFG, 9..12 MATCH 0..3, 13..16 CAPTURE 0..3 (read only). Writable registers read back the value that was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| cap_in | input | 4 | Asynchronous capture/count pins |
| match_out | output | 4 | Match-driven output pins |
| irq | output | 1 | OR of all interrupt flags |

## Verification
A wrong prescale count or counter value shows up on the counter read port within one cycle. It also shifts match events, which then reach `match_out`, the flags and `irq` one edge after the faulty step. A wrong synchronizer depth or edge decode moves the capture value by one count or drops it altogether. A reference model advanced on each edge catches all of these in the first cycle in which the ports diverge.

// File: rtl/tcm_pkg.sv
package tcm_pkg;
  localparam int unsigned REG_CTRL   = 0;
  localparam int unsigned REG_MODE   = 1;
  localparam int unsigned REG_PSLIM  = 2;
  localparam int unsigned REG_PSCNT  = 3;
  localparam int unsigned REG_COUNT  = 4;
  localparam int unsigned REG_FLAGS  = 5;
  localparam int unsigned REG_MACT   = 6;
  localparam int unsigned REG_CCFG   = 7;
  localparam int unsigned REG_OCFG   = 8;
  localparam int unsigned REG_MATCH0 = 9;

  typedef enum logic [1:0] {
    OUT_KEEP = 2'd0,
    OUT_LOW  = 2'd1,
    OUT_HIGH = 2'd2,
    OUT_FLIP = 2'd3
  } out_act_e;

  typedef enum logic [1:0] {
    SRC_PCLK = 2'd0,
    SRC_RISE = 2'd1,
    SRC_FALL = 2'd2,
    SRC_BOTH = 2'd3
  } cnt_src_e;

  // per-channel match action field: bit0 flag, bit1 clear, bit2 stop
  typedef struct packed {
    logic stop;
    logic clear;
    logic irq;
  } mact_t;
endpackage

// File: rtl/tcm_edge_sync.sv
module tcm_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [2:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[1:0], pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  // sh_q[1] is the synchronized level, sh_q[2] its previous value
  assign rise = sh_q[1] & ~sh_q[2];
  assign fall = ~sh_q[1] & sh_q[2];
endmodule

// File: rtl/tcm_count_core.sv
module tcm_count_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             hold_clr,
  input  logic             timer_mode,
  input  logic             ext_step,
  input  logic [CNT_W-1:0] ps_limit,
  input  logic             wrap_hit,
  input  logic             halt_hit,
  output logic             tick,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] ps_count
);
  logic [CNT_W-1:0] cnt_q, cnt_d, ps_q, ps_d;
  logic             ps_hit, active;

  always_comb begin
    active = run & ~hold_clr;
    ps_hit = (ps_q == ps_limit);
    tick   = active & (timer_mode ? ps_hit : ext_step);

    ps_d = ps_q;
    if (hold_clr || !timer_mode) ps_d = '0;
    else if (run)                ps_d = ps_hit ? '0 : ps_q + CNT_W'(1);

    cnt_d = cnt_q;
    if (hold_clr) begin
      cnt_d = '0;
    end else if (tick) begin
      if (wrap_hit)       cnt_d = '0;
      else if (!halt_hit) cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ps_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      ps_q  <= ps_d;
    end
  end

  assign count    = cnt_q;
  assign ps_count = ps_q;
endmodule

// File: rtl/tcm_match_chan.sv
module tcm_match_chan #(
  parameter int CNT_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [CNT_W-1:0]   count,
  input  logic [CNT_W-1:0]   ref_val,
  input  tcm_pkg::out_act_e  act,
  output logic               evt,
  output logic               pin
);
  logic pin_q, pin_d;

  always_comb begin
    evt   = tick && (count == ref_val);
    pin_d = pin_q;
    if (evt) begin
      unique case (act)
        tcm_pkg::OUT_LOW:  pin_d = 1'b0;
        tcm_pkg::OUT_HIGH: pin_d = 1'b1;
        tcm_pkg::OUT_FLIP: pin_d = ~pin_q;
        default:           pin_d = pin_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_d;
  end

  assign pin = pin_q;
endmodule

// File: rtl/tcm_timer.sv
module tcm_timer #(
  parameter int CNT_W  = 32,
  parameter int N_CH   = 4,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [N_CH-1:0]   cap_in,
  output logic [N_CH-1:0]   match_out,
  output logic              irq
);
  import tcm_pkg::*;

  localparam int SRC_W    = (N_CH > 1) ? $clog2(N_CH) : 1;
  localparam int MODE_W   = 2 + SRC_W;
  localparam int FLAG_W   = 2 * N_CH;
  localparam int CFG_W    = 3 * N_CH;
  localparam int OCFG_W   = 2 * N_CH;
  localparam int CAP_BASE = REG_MATCH0 + N_CH;

  // control and configuration state
  logic              run_q, run_d, hclr_q, hclr_d;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic [CNT_W-1:0]  pslim_q, pslim_d;
  logic [CFG_W-1:0]  mact_q, mact_d, ccfg_q, ccfg_d;
  logic [OCFG_W-1:0] ocfg_q, ocfg_d;
  logic [FLAG_W-1:0] flag_q, flag_d;
  logic [CNT_W-1:0]  mr_q [N_CH];
  logic [CNT_W-1:0]  mr_d [N_CH];
  logic [CNT_W-1:0]  cr_q [N_CH];
  logic [CNT_W-1:0]  cr_d [N_CH];

  // datapath nets
  logic [N_CH-1:0]  rise, fall, cap_evt, mevt, m_irq, m_clr, m_stop, c_irq;
  logic             tick, timer_mode, ext_step;
  logic [CNT_W-1:0] count, ps_count;
  logic [SRC_W-1:0] src_sel;
  cnt_src_e         src_kind;

  // write strobes
  logic wr_ctrl, wr_mode, wr_pslim, wr_flags, wr_mact, wr_ccfg, wr_ocfg;
  assign wr_ctrl  = bus_we && (bus_addr == ADDR_W'(REG_CTRL));
  assign wr_mode  = bus_we && (bus_addr == ADDR_W'(REG_MODE));
  assign wr_pslim = bus_we && (bus_addr == ADDR_W'(REG_PSLIM));
  assign wr_flags = bus_we && (bus_addr == ADDR_W'(REG_FLAGS));
  assign wr_mact  = bus_we && (bus_addr == ADDR_W'(REG_MACT));
  assign wr_ccfg  = bus_we && (bus_addr == ADDR_W'(REG_CCFG));
  assign wr_ocfg  = bus_we && (bus_addr == ADDR_W'(REG_OCFG));

  // per-channel synchronizers, capture decode and match units
  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    mact_t ma;
    assign ma = mact_q[3*i +: 3];
    assign m_irq[i]  = ma.irq;
    assign m_clr[i]  = ma.clear;
    assign m_stop[i] = ma.stop;
    assign c_irq[i]  = ccfg_q[3*i+2];

    tcm_edge_sync u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (cap_in[i]),
      .rise (rise[i]),
      .fall (fall[i])
    );

    assign cap_evt[i] = (rise[i] & ccfg_q[3*i]) | (fall[i] & ccfg_q[3*i+1]);

    tcm_match_chan #(.CNT_W(CNT_W)) u_match (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .count  (count),
      .ref_val(mr_q[i]),
      .act    (out_act_e'(ocfg_q[2*i +: 2])),
      .evt    (mevt[i]),
      .pin    (match_out[i])
    );
  end

  // count source selection
  always_comb begin
    src_kind   = cnt_src_e'(mode_q[1:0]);
    src_sel    = mode_q[MODE_W-1:2];
    timer_mode = (src_kind == SRC_PCLK);
    unique case (src_kind)
      SRC_RISE: ext_step = rise[src_sel];
      SRC_FALL: ext_step = fall[src_sel];
      SRC_BOTH: ext_step = rise[src_sel] | fall[src_sel];
      default:  ext_step = 1'b0;
    endcase
  end

  tcm_count_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run_q),
    .hold_clr  (hclr_q),
    .timer_mode(timer_mode),
    .ext_step  (ext_step),
    .ps_limit  (pslim_q),
    .wrap_hit  (|(mevt & m_clr)),
    .halt_hit  (|(mevt & m_stop)),
    .tick      (tick),
    .count     (count),
    .ps_count  (ps_count)
  );

  // next-state for registers
  always_comb begin
    run_d   = run_q;
    hclr_d  = hclr_q;
    mode_d  = mode_q;
    pslim_d = pslim_q;
    mact_d  = mact_q;
    ccfg_d  = ccfg_q;
    ocfg_d  = ocfg_q;
    if (wr_ctrl) begin
      run_d  = bus_wdata[0];
      hclr_d = bus_wdata[1];
    end
    if (|(mevt & m_stop)) run_d = 1'b0;
    if (wr_mode)  mode_d  = bus_wdata[MODE_W-1:0];
    if (wr_pslim) pslim_d = bus_wdata[CNT_W-1:0];
    if (wr_mact)  mact_d  = bus_wdata[CFG_W-1:0];
    if (wr_ccfg)  ccfg_d  = bus_wdata[CFG_W-1:0];
    if (wr_ocfg)  ocfg_d  = bus_wdata[OCFG_W-1:0];

    flag_d = flag_q & ~(wr_flags ? bus_wdata[FLAG_W-1:0] : '0);
    flag_d = flag_d | {cap_evt & c_irq, mevt & m_irq};

    for (int k = 0; k < N_CH; k++) begin
      mr_d[k] = mr_q[k];
      cr_d[k] = cr_q[k];
      if (bus_we && (bus_addr == ADDR_W'(REG_MATCH0 + k))) mr_d[k] = bus_wdata[CNT_W-1:0];
      if (cap_evt[k]) cr_d[k] = count;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      hclr_q  <= 1'b0;
      mode_q  <= '0;
      pslim_q <= '0;
      mact_q  <= '0;
      ccfg_q  <= '0;
      ocfg_q  <= '0;
      flag_q  <= '0;
      for (int k = 0; k < N_CH; k++) begin
        mr_q[k] <= '0;
        cr_q[k] <= '0;
      end
    end else begin
      run_q   <= run_d;
      hclr_q  <= hclr_d;
      mode_q  <= mode_d;
      pslim_q <= pslim_d;
      mact_q  <= mact_d;
      ccfg_q  <= ccfg_d;
      ocfg_q  <= ocfg_d;
      flag_q  <= flag_d;
      for (int k = 0; k < N_CH; k++) begin
        mr_q[k] <= mr_d[k];
        cr_q[k] <= cr_d[k];
      end
    end
  end

  assign irq = |flag_q;

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(REG_CTRL))  bus_rdata = {30'd0, hclr_q, run_q};
    if (bus_addr == ADDR_W'(REG_MODE))  bus_rdata = 32'(mode_q);
    if (bus_addr == ADDR_W'(REG_PSLIM)) bus_rdata = 32'(pslim_q);
    if (bus_addr == ADDR_W'(REG_PSCNT)) bus_rdata = 32'(ps_count);
    if (bus_addr == ADDR_W'(REG_COUNT)) bus_rdata = 32'(count);
    if (bus_addr == ADDR_W'(REG_FLAGS)) bus_rdata = 32'(flag_q);
    if (bus_addr == ADDR_W'(REG_MACT))  bus_rdata = 32'(mact_q);
    if (bus_addr == ADDR_W'(REG_CCFG))  bus_rdata = 32'(ccfg_q);
    if (bus_addr == ADDR_W'(REG_OCFG))  bus_rdata = 32'(ocfg_q);
    for (int k = 0; k < N_CH; k++) begin
      if (bus_addr == ADDR_W'(REG_MATCH0 + k)) bus_rdata = 32'(mr_q[k]);
      if (bus_addr == ADDR_W'(CAP_BASE + k))   bus_rdata = 32'(cr_q[k]);
    end
  end
endmodule

// File: rtl/tcm_timer_chk.sv
module tcm_timer_chk #(
  parameter int CNT_W  = 32,
  parameter int N_CH   = 4,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              irq,
  input logic [N_CH-1:0]   match_out,
  input logic              run_q,
  input logic              hclr_q,
  input logic              timer_mode,
  input logic [CNT_W-1:0]  ps_count,
  input logic [CNT_W-1:0]  pslim_q,
  input logic [CNT_W-1:0]  count,
  input logic [N_CH-1:0]   mevt,
  input logic [N_CH-1:0]   m_stop,
  input logic [2*N_CH-1:0] ocfg_q
);
  assert_hold_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hclr_q |=> (count == '0 && ps_count == '0));

  assert_prescale_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !hclr_q && timer_mode && ps_count != pslim_q) |=> $stable(count));

  assert_idle_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !hclr_q) |=> ($stable(count) && $stable(ps_count)));

  assert_stop_clears_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(mevt & m_stop)) |=> !run_q);

  assert_irq_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(bus_we && bus_addr == ADDR_W'(tcm_pkg::REG_FLAGS))) |=> irq);

  for (genvar i = 0; i < N_CH; i++) begin : g_pin
    assert_toggle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mevt[i] && ocfg_q[2*i +: 2] == 2'b11) |=> (match_out[i] != $past(match_out[i])));
  end
endmodule

bind tcm_timer tcm_timer_chk #(.CNT_W(CNT_W), .N_CH(N_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .irq       (irq),
  .match_out (match_out),
  .run_q     (run_q),
  .hclr_q    (hclr_q),
  .timer_mode(timer_mode),
  .ps_count  (ps_count),
  .pslim_q   (pslim_q),
  .count     (count),
  .mevt      (mevt),
  .m_stop    (m_stop),
  .ocfg_q    (ocfg_q)
);

// File: tb/tb_tcm_timer.sv
`timescale 1ns/1ps
module tb_tcm_timer;
  logic        clk, rst_n, bus_we;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [3:0]  cap_in, match_out;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  tcm_timer dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in),
    .match_out(match_out), .irq(irq)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  // ---------------- reference model ----------------
  bit        m_run, m_hclr;
  bit [3:0]  m_mode, m_s1, m_s2, m_s3, m_out;
  bit [31:0] m_psl, m_psc, m_cnt;
  bit [7:0]  m_flg, m_ocf;
  bit [11:0] m_act, m_ccf;
  bit [31:0] m_mr [4];
  bit [31:0] m_cr [4];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_hclr = 0; m_mode = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_out = 0;
      m_psl = 0; m_psc = 0; m_cnt = 0; m_flg = 0; m_ocf = 0; m_act = 0; m_ccf = 0;
      for (int k = 0; k < 4; k++) begin m_mr[k] = 0; m_cr[k] = 0; end
    end else begin
      bit [3:0] ri, fa, ev;
      bit step, tk, any_clr, any_stop;
      bit [31:0] n_cnt, n_psc;
      bit [7:0] n_flg;
      int src;
      ri = m_s2 & ~m_s3;
      fa = ~m_s2 & m_s3;
      src = m_mode[3:2];
      case (m_mode[1:0])
        2'd1: step = ri[src];
        2'd2: step = fa[src];
        2'd3: step = ri[src] | fa[src];
        default: step = 0;
      endcase
      tk = 0;
      if (m_run && !m_hclr) tk = (m_mode[1:0] == 0) ? (m_psc == m_psl) : step;
      any_clr = 0; any_stop = 0; n_flg = m_flg;
      if (bus_we && bus_addr == 5) n_flg = n_flg & ~bus_wdata[7:0];
      for (int k = 0; k < 4; k++) begin
        ev[k] = tk && (m_cnt == m_mr[k]);
        if (ev[k]) begin
          if (m_act[3*k+1]) any_clr = 1;
          if (m_act[3*k+2]) any_stop = 1;
          if (m_act[3*k])   n_flg[k] = 1;
          case (m_ocf[2*k +: 2])
            2'd1: m_out[k] = 0;
            2'd2: m_out[k] = 1;
            2'd3: m_out[k] = ~m_out[k];
            default: ;
          endcase
        end
        if ((ri[k] && m_ccf[3*k]) || (fa[k] && m_ccf[3*k+1])) begin
          m_cr[k] = m_cnt;
          if (m_ccf[3*k+2]) n_flg[4+k] = 1;
        end
      end
      n_cnt = m_cnt;
      if (m_hclr) n_cnt = 0;
      else if (tk) n_cnt = any_clr ? 0 : (any_stop ? m_cnt : m_cnt + 1);
      n_psc = m_psc;
      if (m_hclr || m_mode[1:0] != 0) n_psc = 0;
      else if (m_run) n_psc = (m_psc == m_psl) ? 0 : m_psc + 1;
      m_cnt = n_cnt; m_psc = n_psc; m_flg = n_flg;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = cap_in;
      if (bus_we) begin
        case (bus_addr)
          5'd0: begin m_run = bus_wdata[0]; m_hclr = bus_wdata[1]; end
          5'd1: m_mode = bus_wdata[3:0];
          5'd2: m_psl = bus_wdata;
          5'd6: m_act = bus_wdata[11:0];
          5'd7: m_ccf = bus_wdata[11:0];
          5'd8: m_ocf = bus_wdata[7:0];
          5'd9, 5'd10, 5'd11, 5'd12: m_mr[bus_addr - 9] = bus_wdata;
          default: ;
        endcase
      end
      if (any_stop) m_run = 0;
    end
  end

  function automatic bit [31:0] mrd(input bit [4:0] a);
    case (a)
      5'd0: mrd = {30'd0, m_hclr, m_run};
      5'd1: mrd = {28'd0, m_mode};
      5'd2: mrd = m_psl;
      5'd3: mrd = m_psc;
      5'd4: mrd = m_cnt;
      5'd5: mrd = {24'd0, m_flg};
      5'd6: mrd = {20'd0, m_act};
      5'd7: mrd = {20'd0, m_ccf};
      5'd8: mrd = {24'd0, m_ocf};
      5'd9, 5'd10, 5'd11, 5'd12: mrd = m_mr[a - 9];
      5'd13, 5'd14, 5'd15, 5'd16: mrd = m_cr[a - 13];
      default: mrd = 0;
    endcase
  endfunction

  task automatic check(input string req, input bit [31:0] act, input bit [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // compare against the model on every clock
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      check("R14 model read", bus_rdata, mrd(bus_addr));
      check("R10 model pins", {28'd0, match_out}, {28'd0, m_out});
      check("R11 model irq", {31'd0, irq}, {31'd0, (m_flg != 0)});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input bit [4:0] a, input bit [31:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0; bus_wdata = 0;
  endtask

  task automatic rd_chk(input string req, input bit [4:0] a, input bit [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1 check(req, bus_rdata, exp);
  endtask

  task automatic pulse(input int ch, input int n);
    for (int p = 0; p < n; p++) begin
      @(negedge clk); cap_in[ch] = 1;
      repeat (4) @(negedge clk);
      cap_in[ch] = 0;
      repeat (4) @(negedge clk);
    end
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit [31:0] c;
    rst_n = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0; cap_in = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    for (int a = 0; a < 17; a++) rd_chk("R1 reset reg", 5'(a), 0);
    check("R1 reset pins", {28'd0, match_out}, 0);
    check("R1 reset irq", {31'd0, irq}, 0);

    // R2: prescale limit 2 -> one step every 3 cycles
    wr(5'd2, 32'd2);
    wr(5'd0, 32'd1);
    bus_addr = 5'd4;
    repeat (9) @(posedge clk);
    #2 check("R2 count after 9 cycles", bus_rdata, 32'd3);

    // R4: stopped counter holds
    wr(5'd0, 32'd0);
    @(negedge clk); bus_addr = 5'd4; #1 c = bus_rdata;
    repeat (6) @(negedge clk);
    rd_chk("R4 frozen count", 5'd4, c);

    // R3: hold forces zero
    wr(5'd0, 32'd2);
    rd_chk("R3 count held zero", 5'd4, 0);
    rd_chk("R3 prescale held zero", 5'd3, 0);
    wr(5'd0, 32'd0);

    // R7 R9 R10: stop on match 5, flag, drive pin high
    wr(5'd2, 32'd0);
    wr(5'd10, 32'd5);
    wr(5'd6, 32'h28);
    wr(5'd8, 32'h8);
    wr(5'd0, 32'd1);
    repeat (20) @(negedge clk);
    rd_chk("R9 run cleared by stop", 5'd0, 0);
    rd_chk("R9 count frozen at match", 5'd4, 5);
    rd_chk("R7 match flag set", 5'd5, 32'h2);
    check("R10 pin driven high", {28'd0, match_out}, 32'h2);
    check("R11 irq high with flag", {31'd0, irq}, 1);

    // R11: write one to clear
    wr(5'd5, 32'h2);
    rd_chk("R11 flag cleared", 5'd5, 0);
    check("R11 irq low", {31'd0, irq}, 0);

    // R8 R10: wrap at 3 (period 4), toggle pin 0
    wr(5'd0, 32'd2);
    wr(5'd9, 32'd3);
    wr(5'd6, 32'h3);
    wr(5'd8, 32'h3);
    wr(5'd0, 32'd1);
    bus_addr = 5'd4;
    repeat (4) @(posedge clk);
    #2 check("R8 wrapped to zero", bus_rdata, 0);
    check("R10 toggled high", {31'd0, match_out[0]}, 1);
    repeat (4) @(posedge clk);
    #2 check("R8 wrapped again", bus_rdata, 0);
    check("R10 toggled low", {31'd0, match_out[0]}, 0);

    // R5 R6: captures on a stopped counter
    wr(5'd0, 32'd0);
    @(negedge clk); bus_addr = 5'd4; #1 c = bus_rdata;
    wr(5'd5, 32'hFF);
    wr(5'd7, 32'h540);
    pulse(2, 1);
    rd_chk("R5 rising capture ch2", 5'd15, c);
    rd_chk("R6 capture flag enabled", 5'd5, 32'h40);
    pulse(3, 1);
    rd_chk("R5 falling capture ch3", 5'd16, c);
    rd_chk("R6 capture flag disabled", 5'd5, 32'h40);

    // R13: two-flop latency, free-running count
    wr(5'd6, 32'd0);
    wr(5'd0, 32'd2);
    wr(5'd0, 32'd1);
    bus_addr = 5'd4;
    @(posedge clk); #2 c = bus_rdata;
    @(negedge clk); cap_in[2] = 1;
    repeat (6) @(negedge clk);
    cap_in[2] = 0;
    wr(5'd0, 32'd0);
    rd_chk("R13 capture latency", 5'd15, c + 2);

    // R12: counter mode on cap_in[2]
    wr(5'd0, 32'd2);
    wr(5'd1, 32'h9);
    wr(5'd0, 32'd1);
    pulse(2, 3);
    repeat (4) @(negedge clk);
    rd_chk("R12 rising edges counted", 5'd4, 3);
    rd_chk("R12 prescale idle", 5'd3, 0);
    wr(5'd1, 32'hB);
    pulse(2, 2);
    repeat (4) @(negedge clk);
    rd_chk("R12 both edges counted", 5'd4, 7);
    wr(5'd0, 32'd0);

    // R14: readback
    wr(5'd12, 32'hDEADBEEF);
    rd_chk("R14 match readback", 5'd12, 32'hDEADBEEF);
    rd_chk("R14 capture config readback", 5'd7, 32'h540);
    rd_chk("R14 mode readback", 5'd1, 32'hB);

    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule